// File: doc/BRIEF.md
# Trigger-Armed Synthesizer Register Writer

This block turns 32-bit control words from a host into byte-wide register writes for a pair of synthesizer channels. Each word names one synthesizer register, a data byte and the channels to write. Either channel or both can be targeted. The same word also loads two configuration levels: an external-clock select and an arm flag.

When the arm flag is set, the block writes to the synthesizers on its own. A TTL trigger input is passed through a synchronizer and its edges are detected. Each edge issues one fixed write to a frequency-control register on both channels. A rising edge writes one byte and a falling edge writes another. Every such write also raises an update pulse, so settings the host staged earlier take effect on the trigger edge. This allows dwell, sweep, dwell sequences to run with no host action. If a host write and a trigger write fall in the same cycle, the trigger write goes out first and the host write follows one cycle later.

Usage constraints: host writes arrive at most every other cycle. The trigger holds each level for at least two cycles.

Top module: `trig_reg_writer`

## Requirements
- R1: A control write with bit 14 or bit 15 set produces a single-cycle `syn_we_o` on the next clock edge. On that edge `syn_addr_o` equals word bits 13:8 and `syn_data_o` equals bits 7:0. `syn_sel_a_o` equals bit 14, `syn_sel_b_o` equals bit 15, and `upd_o` stays low.
- R2: A control write with both bit 14 and bit 15 clear produces no synthesizer write.
- R3: Every control write loads the arm flag from bit 17 and `ext_clk_o` from bit 16. Both take effect at the edge that captures the write.
- R4: The trigger passes through a two-flop synchronizer. A trigger level change first sampled at clock edge k produces its write at edge k+2.
- R5: While armed, a rising trigger edge writes 0xC0 to register address 0x02 with both channel selects high.
- R6: While armed, a falling trigger edge writes 0x00 to register address 0x02 with both channel selects high.
- R7: Every trigger-driven write asserts `upd_o` in the same cycle as `syn_we_o`. Host-driven writes never assert `upd_o`.
- R8: While disarmed, trigger edges produce neither a write nor an update pulse.
- R9: Each detected edge yields exactly one write of one cycle. A steady trigger level yields none.
- R10: If a trigger write and a host write are due in the same cycle, the trigger write is issued first. The host write follows unchanged on the next cycle.
- R11: After reset, `syn_we_o`, `upd_o` and `ext_clk_o` are low and the block is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control-word write strobe |
| ctl_word_i | input | 32 | Control word: data 7:0, address 13:8, select A 14, select B 15, ext clock 16, arm 17 |
| trig_i | input | 1 | Asynchronous TTL trigger |
| syn_we_o | output | 1 | Synthesizer register write strobe |
| syn_addr_o | output | 6 | Synthesizer register address |
| syn_data_o | output | 8 | Synthesizer data byte |
| syn_sel_a_o | output | 1 | Write targets channel A |
| syn_sel_b_o | output | 1 | Write targets channel B |
| upd_o | output | 1 | Update-event pulse |
| ext_clk_o | output | 1 | External clock select level |

## Verification
The assertions check several rules on every cycle:
- a rising and a falling edge are never flagged together, and no edge is flagged twice in a row;
- an armed edge is followed by a write with the matching byte and an update pulse;
- an edge while disarmed brings no update;
- a host write that collides with a trigger write is parked and then issued without an update pulse;
- every write strobe carries at least one channel select.

Some properties can only be shown by the bench's directed scenarios. These are the exact field mapping from the control word, the arm and external-clock levels taking effect, the end-to-end latency through the synchronizer, and the absence of writes for a steady trigger or a word with no channel bits.

// File: rtl/trw_pkg.sv
package trw_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CW_W   = 32;

  // control word field positions
  localparam int unsigned CW_DATA_LO = 0;
  localparam int unsigned CW_ADDR_LO = 8;
  localparam int unsigned CW_SEL_A   = 14;
  localparam int unsigned CW_SEL_B   = 15;
  localparam int unsigned CW_EXT_CLK = 16;
  localparam int unsigned CW_ARM     = 17;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              sel_a;
    logic              sel_b;
  } syn_wr_t;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], trig_i};
  end

  assign rise_o =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall_o = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];

  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o})); // R9
  AST_NO_DOUBLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9
  AST_NO_DOUBLE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R9
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import trw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctl_we_i,
  input  logic [CW_W-1:0] ctl_word_i,
  output logic            host_vld_o,
  output syn_wr_t         host_wr_o,
  output logic            armed_o,
  output logic            ext_clk_o
);
  logic unused_hi;
  assign unused_hi = ^ctl_word_i[CW_W-1:CW_ARM+1];

  assign host_wr_o.addr  = ctl_word_i[CW_ADDR_LO +: ADDR_W];
  assign host_wr_o.data  = ctl_word_i[CW_DATA_LO +: DATA_W];
  assign host_wr_o.sel_a = ctl_word_i[CW_SEL_A];
  assign host_wr_o.sel_b = ctl_word_i[CW_SEL_B];
  assign host_vld_o      = ctl_we_i & (ctl_word_i[CW_SEL_A] | ctl_word_i[CW_SEL_B]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o   <= 1'b0;
      ext_clk_o <= 1'b0;
    end else if (ctl_we_i) begin
      armed_o   <= ctl_word_i[CW_ARM];
      ext_clk_o <= ctl_word_i[CW_EXT_CLK];
    end
  end

  AST_ARM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> armed_o == $past(ctl_word_i[CW_ARM])); // R3
endmodule

// File: rtl/wr_arbiter.sv
module wr_arbiter
  import trw_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    trig_evt_i,
  input  syn_wr_t trig_wr_i,
  input  logic    host_vld_i,
  input  syn_wr_t host_wr_i,
  output logic    syn_we_o,
  output syn_wr_t syn_wr_o,
  output logic    upd_o
);
  logic    pend_vld_q;
  syn_wr_t pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      syn_we_o   <= 1'b0;
      upd_o      <= 1'b0;
      syn_wr_o   <= '0;
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
    end else begin
      syn_we_o <= 1'b0;
      upd_o    <= 1'b0;
      if (trig_evt_i) begin
        // trigger wins; a colliding host write is parked
        syn_we_o <= 1'b1;
        upd_o    <= 1'b1;
        syn_wr_o <= trig_wr_i;
        if (host_vld_i) begin
          pend_vld_q <= 1'b1;
          pend_q     <= host_wr_i;
        end
      end else if (pend_vld_q) begin
        syn_we_o   <= 1'b1;
        syn_wr_o   <= pend_q;
        pend_vld_q <= host_vld_i;
        pend_q     <= host_wr_i;
      end else if (host_vld_i) begin
        syn_we_o <= 1'b1;
        syn_wr_o <= host_wr_i;
      end
    end
  end

  AST_PARK_ON_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_evt_i && host_vld_i) |=> pend_vld_q && upd_o); // R10
  AST_PARKED_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vld_q && !trig_evt_i) |=> syn_we_o && !upd_o); // R10
  AST_HOST_NO_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_vld_i && !trig_evt_i && !pend_vld_q) |=> syn_we_o && !upd_o); // R7
  AST_SEL_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_we_o |-> (syn_wr_o.sel_a || syn_wr_o.sel_b)); // R2
endmodule

// File: rtl/trig_reg_writer.sv
module trig_reg_writer
  import trw_pkg::*;
#(
  parameter int unsigned          SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0]    TRIG_ADDR   = 6'h02,
  parameter logic [DATA_W-1:0]    RISE_DATA   = 8'hC0,
  parameter logic [DATA_W-1:0]    FALL_DATA   = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [CW_W-1:0]   ctl_word_i,
  input  logic              trig_i,
  output logic              syn_we_o,
  output logic [ADDR_W-1:0] syn_addr_o,
  output logic [DATA_W-1:0] syn_data_o,
  output logic              syn_sel_a_o,
  output logic              syn_sel_b_o,
  output logic              upd_o,
  output logic              ext_clk_o
);
  logic    rise, fall, armed, host_vld, trig_evt;
  syn_wr_t host_wr, trig_wr, out_wr;

  trig_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  ctl_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_we_i  (ctl_we_i),
    .ctl_word_i(ctl_word_i),
    .host_vld_o(host_vld),
    .host_wr_o (host_wr),
    .armed_o   (armed),
    .ext_clk_o (ext_clk_o)
  );

  assign trig_evt      = armed & (rise | fall);
  assign trig_wr.addr  = TRIG_ADDR;
  assign trig_wr.data  = rise ? RISE_DATA : FALL_DATA;
  assign trig_wr.sel_a = 1'b1;
  assign trig_wr.sel_b = 1'b1;

  wr_arbiter u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_evt_i(trig_evt),
    .trig_wr_i (trig_wr),
    .host_vld_i(host_vld),
    .host_wr_i (host_wr),
    .syn_we_o  (syn_we_o),
    .syn_wr_o  (out_wr),
    .upd_o     (upd_o)
  );

  assign syn_addr_o  = out_wr.addr;
  assign syn_data_o  = out_wr.data;
  assign syn_sel_a_o = out_wr.sel_a;
  assign syn_sel_b_o = out_wr.sel_b;

  AST_RISE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && rise) |=> syn_we_o && upd_o && syn_data_o == RISE_DATA
                        && syn_addr_o == TRIG_ADDR); // R5
  AST_FALL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && fall) |=> syn_we_o && upd_o && syn_data_o == FALL_DATA
                        && syn_addr_o == TRIG_ADDR); // R6
  AST_DISARMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && (rise || fall)) |=> !upd_o); // R8
  AST_UPD_WITH_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> syn_we_o && syn_sel_a_o && syn_sel_b_o); // R7
endmodule

// File: tb/sim_trig_reg_writer.sv
`timescale 1ns/1ps
module sim_trig_reg_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_word = '0;
  logic        trig = 1'b0;
  logic        syn_we, sel_a, sel_b, upd, ext_clk;
  logic [5:0]  addr;
  logic [7:0]  data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  trig_reg_writer u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ctl_we_i   (ctl_we),
    .ctl_word_i (ctl_word),
    .trig_i     (trig),
    .syn_we_o   (syn_we),
    .syn_addr_o (addr),
    .syn_data_o (data),
    .syn_sel_a_o(sel_a),
    .syn_sel_b_o(sel_b),
    .upd_o      (upd),
    .ext_clk_o  (ext_clk)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected output bundle {we,upd,sel_a,sel_b,addr,data}
  function automatic logic [17:0] pack(input logic we, input logic u, input logic a,
                                       input logic b, input logic [5:0] ad, input logic [7:0] d);
    return {we, u, a, b, ad, d};
  endfunction

  function automatic logic [17:0] obs();
    return pack(syn_we, upd, sel_a, sel_b, addr, data);
  endfunction

  task automatic host_wr(input logic [31:0] w);
    ctl_we = 1'b1;
    ctl_word = w;
    tick();
    ctl_we = 1'b0;
  endtask

  function automatic logic [31:0] mkw(input bit arm, input bit ec, input bit b, input bit a,
                                      input logic [5:0] ad, input logic [7:0] d);
    return {14'd0, arm, ec, b, a, ad, d};
  endfunction

  task automatic t_reset();
    chk(syn_we == 1'b0 && upd == 1'b0 && ext_clk == 1'b0, "R11 reset outputs",
        {29'd0, syn_we, upd, ext_clk}, 32'd0);
  endtask

  task automatic t_host_single();
    host_wr(mkw(0, 0, 0, 1, 6'h15, 8'h3C));
    chk(obs() == pack(1, 0, 1, 0, 6'h15, 8'h3C), "R1 host write A", {14'd0, obs()},
        {14'd0, pack(1, 0, 1, 0, 6'h15, 8'h3C)});
    tick();
    chk(syn_we == 1'b0, "R1 strobe one cycle", {31'd0, syn_we}, 32'd0);
    host_wr(mkw(0, 0, 1, 1, 6'h3F, 8'hA5));
    chk(obs() == pack(1, 0, 1, 1, 6'h3F, 8'hA5), "R1 host write both / R7 no upd",
        {14'd0, obs()}, {14'd0, pack(1, 0, 1, 1, 6'h3F, 8'hA5)});
    tick();
    host_wr(mkw(0, 0, 1, 0, 6'h02, 8'h11));
    chk(obs() == pack(1, 0, 0, 1, 6'h02, 8'h11), "R7 host to trig addr no upd",
        {14'd0, obs()}, {14'd0, pack(1, 0, 0, 1, 6'h02, 8'h11)});
    tick();
  endtask

  task automatic t_no_sel();
    host_wr(mkw(0, 1, 0, 0, 6'h07, 8'hFF));
    chk(syn_we == 1'b0, "R2 no channel no write", {31'd0, syn_we}, 32'd0);
    chk(ext_clk == 1'b1, "R3 ext clock set", {31'd0, ext_clk}, 32'd1);
    tick();
    chk(syn_we == 1'b0, "R2 still quiet", {31'd0, syn_we}, 32'd0);
    host_wr(mkw(0, 0, 0, 0, 6'h00, 8'h00));
    chk(ext_clk == 1'b0, "R3 ext clock cleared", {31'd0, ext_clk}, 32'd0);
    tick();
  endtask

  task automatic t_disarmed();
    trig = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(syn_we == 1'b0 && upd == 1'b0, "R8 disarmed rise ignored", {30'd0, syn_we, upd}, 32'd0);
    end
    trig = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(syn_we == 1'b0 && upd == 1'b0, "R8 disarmed fall ignored", {30'd0, syn_we, upd}, 32'd0);
    end
  endtask

  task automatic t_armed_edges();
    host_wr(mkw(1, 0, 0, 0, 6'h00, 8'h00));
    tick();
    trig = 1'b1;
    tick();
    tick();
    chk(syn_we == 1'b0, "R4 no write before latency", {31'd0, syn_we}, 32'd0);
    tick();
    chk(obs() == pack(1, 1, 1, 1, 6'h02, 8'hC0), "R5 R4 R7 rise write", {14'd0, obs()},
        {14'd0, pack(1, 1, 1, 1, 6'h02, 8'hC0)});
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(syn_we == 1'b0 && upd == 1'b0, "R9 steady high no write", {30'd0, syn_we, upd}, 32'd0);
    end
    trig = 1'b0;
    tick();
    tick();
    chk(syn_we == 1'b0, "R4 fall latency", {31'd0, syn_we}, 32'd0);
    tick();
    chk(obs() == pack(1, 1, 1, 1, 6'h02, 8'h00), "R6 fall write", {14'd0, obs()},
        {14'd0, pack(1, 1, 1, 1, 6'h02, 8'h00)});
    tick();
    chk(syn_we == 1'b0, "R9 one write per edge", {31'd0, syn_we}, 32'd0);
  endtask

  task automatic t_collide();
    trig = 1'b1;
    tick();
    tick();
    // edge is now detected; host write lands in the same cycle
    ctl_we = 1'b1;
    ctl_word = mkw(1, 0, 1, 0, 6'h2A, 8'h5B);
    tick();
    ctl_we = 1'b0;
    chk(obs() == pack(1, 1, 1, 1, 6'h02, 8'hC0), "R10 trigger first", {14'd0, obs()},
        {14'd0, pack(1, 1, 1, 1, 6'h02, 8'hC0)});
    tick();
    chk(obs() == pack(1, 0, 0, 1, 6'h2A, 8'h5B), "R10 host second", {14'd0, obs()},
        {14'd0, pack(1, 0, 0, 1, 6'h2A, 8'h5B)});
    tick();
    chk(syn_we == 1'b0, "R10 no extra write", {31'd0, syn_we}, 32'd0);
  endtask

  task automatic t_disarm();
    host_wr(mkw(0, 0, 0, 0, 6'h00, 8'h00));
    trig = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(upd == 1'b0 && syn_we == 1'b0, "R3 R8 disarmed by write", {30'd0, syn_we, upd}, 32'd0);
    end
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_host_single();
    t_no_sel();
    t_disarmed();
    t_armed_edges();
    t_collide();
    t_disarm();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule